// File: doc/BRIEF.md
# Eight-Channel Stereo Gain and Pan Mixer

This block sums eight signed sample streams into one left and one right output code. Each channel passes through three gain stages before it is summed. The first is its own attenuation, set in 2 dB steps. The second is a separate left and right attenuation that places the channel in the stereo field. The third is a global power-of-two scale that applies to every channel. The sum is converted to a 14-bit offset-binary code that saturates at its limits, ready for a converter that takes unsigned codes.

A sample strobe starts a frame. On the strobe edge the block captures all channel samples and their active flags. It then walks the channels one per clock through a single shared datapath. When the last channel has been added, both output codes change together and a one-cycle valid pulse marks the new pair. Gain settings are written through a small strobed write port: one write selects a channel's volume, a channel's pan byte, or the global scale.

Top module: `pan_mixer8`

## Requirements
- R1: While reset is high, both output codes read 8192 and the valid flag is low. Reset also sets every channel volume code and pan byte to 0 (0 dB) and the global scale code to 0.
- R2: The volume code n (0..15) attenuates by 2·n dB. Its gain is the 9-bit fraction g/512, where g for n=0..15 is 511, 406, 322, 256, 203, 162, 128, 102, 81, 64, 51, 41, 32, 26, 20, 16. Applying a gain gives floor(x·g/512).
- R3: In the pan byte, bits 7:4 are the left attenuation code and bits 3:0 are the right attenuation code. Both use the same table as R2, and the pan gain is applied after the volume gain.
- R4: The global scale code (write-data bits 1:0) divides every channel's contribution by 1, 2, 4 or 8 for codes 0, 1, 2 and 3, using an arithmetic right shift after both gains. The write kind is 0 for volume (data bits 3:0), 1 for pan (bits 7:0) and 2 for global scale. A write with kind 3 changes nothing.
- R5: Each side's sum is the total, over the channels, of floor(floor(floor(s·gv/512)·gp/512)/2^G).
- R6: A channel whose active flag was low at the strobe adds zero, which is the mid-scale level.
- R7: Each output code is floor(sum/4)+8192, clamped to the range 0..16383. The sum saturates at those limits and never wraps.
- R8: The valid pulse lasts exactly one cycle. It appears 8 clock edges after the edge that accepted the strobe. Both output codes change only on that pulse and hold their value at all other times.
- R9: A strobe that arrives while a frame is in progress is ignored. It produces no second result and does not alter the current one.
- R10: Samples and active flags are captured on the accepting strobe edge. Changes on the sample inputs after that edge do not affect the frame's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_sample | input | NCH*SW | Signed samples, channel k in bits k*SW+SW-1 : k*SW |
| ch_active | input | NCH | Per-channel active flag, bit k for channel k |
| frame_strobe | input | 1 | Starts a mixing frame when the block is idle |
| wr_en | input | 1 | Setting write strobe |
| wr_kind | input | 2 | 0 volume, 1 pan, 2 global scale, 3 no effect |
| wr_chan | input | log2(NCH) | Target channel for volume and pan writes |
| wr_data | input | 8 | Setting value |
| out_left | output | OW | Left offset-binary output code |
| out_right | output | OW | Right offset-binary output code |
| out_valid | output | 1 | One-cycle pulse marking a new output pair |

## Verification
A wrong gain-table entry, pan nibble swap or scale shift shows up in the very next frame's output pair. The error is off by a ratio that follows from the affected code. A corrupted channel index or a stale accumulator shows up as a sum that includes the wrong channels, again within one frame of eight cycles. A busy flag that is stuck, or that clears too early, shows up at once in when the valid pulse appears and how often it repeats. A broken capture stage shows up as a frame result that follows samples changed after the strobe.

// File: rtl/pan_mixer8_pkg.sv
package pan_mixer8_pkg;

  localparam int GAIN_W = 9;
  localparam int CODE_W = 4;

  typedef enum logic [1:0] {
    WK_VOL  = 2'd0,
    WK_PAN  = 2'd1,
    WK_GLOB = 2'd2,
    WK_NOP  = 2'd3
  } wr_kind_e;

  // 2 dB attenuation steps as unsigned fractions of 512, 0 dB at the top code
  function automatic logic [GAIN_W-1:0] atten_gain(input logic [CODE_W-1:0] code);
    logic [GAIN_W-1:0] g;
    case (code)
      4'd0:    g = 9'd511;
      4'd1:    g = 9'd406;
      4'd2:    g = 9'd322;
      4'd3:    g = 9'd256;
      4'd4:    g = 9'd203;
      4'd5:    g = 9'd162;
      4'd6:    g = 9'd128;
      4'd7:    g = 9'd102;
      4'd8:    g = 9'd81;
      4'd9:    g = 9'd64;
      4'd10:   g = 9'd51;
      4'd11:   g = 9'd41;
      4'd12:   g = 9'd32;
      4'd13:   g = 9'd26;
      4'd14:   g = 9'd20;
      default: g = 9'd16;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/mix_scale.sv
module mix_scale #(
  parameter int SW = 16,
  parameter int GW = 9
) (
  input  logic signed [SW-1:0] x,
  input  logic        [GW-1:0] g,
  output logic signed [SW-1:0] y
);
  localparam int PW = SW + GW + 1;

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shr;
  logic                 unused_hi;

  assign prod      = PW'(x) * $signed({1'b0, g});
  assign shr       = prod >>> GW;
  assign y         = shr[SW-1:0];
  assign unused_hi = ^shr[PW-1:SW];
endmodule

// File: rtl/mix_regs.sv
module mix_regs
  import pan_mixer8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [CW-1:0]     wr_chan,
  input  logic [7:0]        wr_data,
  input  logic [CW-1:0]     rd_idx,
  output logic [CODE_W-1:0] vol_code,
  output logic [7:0]        pan_code,
  output logic [1:0]        glob_code
);
  logic [CODE_W-1:0] vol_q [NCH];
  logic [7:0]        pan_q [NCH];
  logic [1:0]        glob_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NCH; k++) begin
        vol_q[k] <= '0;
        pan_q[k] <= '0;
      end
      glob_q <= '0;
    end else if (wr_en) begin
      case (wr_kind_e'(wr_kind))
        WK_VOL:  vol_q[wr_chan] <= wr_data[CODE_W-1:0];
        WK_PAN:  pan_q[wr_chan] <= wr_data;
        WK_GLOB: glob_q         <= wr_data[1:0];
        default: ;
      endcase
    end
  end

  assign vol_code  = vol_q[rd_idx];
  assign pan_code  = pan_q[rd_idx];
  assign glob_code = glob_q;
endmodule

// File: rtl/mix_lane.sv
module mix_lane
  import pan_mixer8_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic signed [SW-1:0]    sample,
  input  logic                    active,
  input  logic [CODE_W-1:0]       vol_code,
  input  logic [7:0]              pan_code,
  input  logic [1:0]              glob_code,
  output logic [1:0][SW-1:0]      contrib
);
  logic signed [SW-1:0] s_in;
  logic signed [SW-1:0] s_vol;

  assign s_in = active ? sample : '0;

  mix_scale #(.SW(SW), .GW(GAIN_W)) i_vol (
    .x(s_in), .g(atten_gain(vol_code)), .y(s_vol)
  );

  // side 1 = left (upper nibble), side 0 = right (lower nibble)
  for (genvar sd = 0; sd < 2; sd++) begin : g_side
    logic signed [SW-1:0] s_pan;
    mix_scale #(.SW(SW), .GW(GAIN_W)) i_pan (
      .x(s_vol), .g(atten_gain(pan_code[sd*CODE_W +: CODE_W])), .y(s_pan)
    );
    assign contrib[sd] = s_pan >>> glob_code;
  end
endmodule

// File: rtl/pan_mixer8.sv
module pan_mixer8
  import pan_mixer8_pkg::*;
#(
  parameter int NCH = 8,
  parameter int SW  = 16,
  parameter int OW  = 14,
  parameter int CW  = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH*SW-1:0] ch_sample,
  input  logic [NCH-1:0]    ch_active,
  input  logic              frame_strobe,
  input  logic              wr_en,
  input  logic [1:0]        wr_kind,
  input  logic [CW-1:0]     wr_chan,
  input  logic [7:0]        wr_data,
  output logic [OW-1:0]     out_left,
  output logic [OW-1:0]     out_right,
  output logic              out_valid
);
  localparam int ACW = SW + CW;
  localparam int SHR = SW - OW;
  localparam logic [OW-1:0] MID  = OW'(2 ** (OW - 1));
  localparam logic [OW-1:0] MAXC = {OW{1'b1}};

  logic signed [SW-1:0]  smp_q [NCH];
  logic [NCH-1:0]        act_q;
  logic                  busy;
  logic [CW-1:0]         idx;
  logic [1:0][ACW-1:0]   acc;
  logic [1:0][SW-1:0]    contrib;
  logic [1:0][OW-1:0]    code_nx;
  logic [1:0][ACW-1:0]   sum_nx;
  logic [CODE_W-1:0]     vol_code;
  logic [7:0]            pan_code;
  logic [1:0]            glob_code;
  logic                  take;
  logic                  last;

  assign take = frame_strobe && !busy;
  assign last = busy && (idx == CW'(NCH - 1));

  mix_regs #(.NCH(NCH), .CW(CW)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_chan(wr_chan), .wr_data(wr_data), .rd_idx(idx),
    .vol_code(vol_code), .pan_code(pan_code), .glob_code(glob_code)
  );

  mix_lane #(.SW(SW)) i_lane (
    .sample(smp_q[idx]), .active(act_q[idx]), .vol_code(vol_code),
    .pan_code(pan_code), .glob_code(glob_code), .contrib(contrib)
  );

  // capture stage: plain storage, no reset, written only on accept
  always_ff @(posedge clk) begin
    if (take) begin
      for (int k = 0; k < NCH; k++) smp_q[k] <= ch_sample[k*SW +: SW];
    end
  end

  for (genvar sd = 0; sd < 2; sd++) begin : g_out
    logic signed [ACW:0] biased;
    assign sum_nx[sd] = acc[sd] + {{CW{contrib[sd][SW-1]}}, contrib[sd]};
    assign biased     = ($signed({sum_nx[sd][ACW-1], sum_nx[sd]}) >>> SHR)
                        + $signed((ACW + 1)'(MID));
    always_comb begin
      if (biased[ACW])               code_nx[sd] = '0;
      else if (|biased[ACW-1:OW])    code_nx[sd] = MAXC;
      else                           code_nx[sd] = biased[OW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= '0;
      busy      <= 1'b0;
      idx       <= '0;
      acc       <= '0;
      out_left  <= MID;
      out_right <= MID;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      if (take) begin
        act_q <= ch_active;
        busy  <= 1'b1;
        idx   <= '0;
        acc   <= '0;
      end else if (busy) begin
        acc <= sum_nx;
        idx <= idx + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          out_left  <= code_nx[1];
          out_right <= code_nx[0];
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pan_mixer8_chk.sv
module pan_mixer8_chk #(
  parameter int NCH = 8,
  parameter int OW  = 14
) (
  input logic          clk,
  input logic          rst,
  input logic          frame_strobe,
  input logic [OW-1:0] out_left,
  input logic [OW-1:0] out_right,
  input logic          out_valid
);
  localparam int TW = $clog2(NCH + 1) + 1;
  localparam logic [OW-1:0] MID = OW'(2 ** (OW - 1));

  // independent frame timer: counts edges since an accepted strobe
  logic [TW-1:0] tmr;
  always_ff @(posedge clk) begin
    if (rst)                            tmr <= '0;
    else if (tmr == '0 && frame_strobe) tmr <= TW'(1);
    else if (tmr == TW'(NCH))           tmr <= '0;
    else if (tmr != '0)                 tmr <= tmr + 1'b1;
  end

  assert_reset_mid_R1: assert property (@(posedge clk)
    rst |=> (out_left == MID && out_right == MID && !out_valid));

  assert_due_valid_R8: assert property (@(posedge clk) disable iff (rst)
    (tmr == TW'(NCH)) |=> out_valid);

  assert_no_early_valid_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($past(tmr) == TW'(NCH)));

  assert_single_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_hold_outputs_R8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> ($stable(out_left) && $stable(out_right)));
endmodule

bind pan_mixer8 pan_mixer8_chk #(.NCH(NCH), .OW(OW)) i_chk (
  .clk(clk), .rst(rst), .frame_strobe(frame_strobe),
  .out_left(out_left), .out_right(out_right), .out_valid(out_valid)
);

// File: tb/test_pan_mixer8.sv
module test_pan_mixer8;
  localparam int NCH = 8;
  localparam int SW  = 16;
  localparam int OW  = 14;
  localparam int CW  = 3;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic              rst = 1'b1;
  logic [NCH*SW-1:0] ch_sample = '0;
  logic [NCH-1:0]    ch_active = '0;
  logic              frame_strobe = 1'b0;
  logic              wr_en = 1'b0;
  logic [1:0]        wr_kind = '0;
  logic [CW-1:0]     wr_chan = '0;
  logic [7:0]        wr_data = '0;
  logic [OW-1:0]     out_left, out_right;
  logic              out_valid;

  pan_mixer8 i_pan_mixer8 (
    .clk(clk), .rst(rst), .ch_sample(ch_sample), .ch_active(ch_active),
    .frame_strobe(frame_strobe), .wr_en(wr_en), .wr_kind(wr_kind),
    .wr_chan(wr_chan), .wr_data(wr_data), .out_left(out_left),
    .out_right(out_right), .out_valid(out_valid)
  );

  int checks = 0;
  int errors = 0;
  int vol_m [NCH];
  int pan_m [NCH];
  int smp_m [NCH];
  int glob_m;
  logic [NCH-1:0] act_m;

  localparam int GTAB [16] = '{511, 406, 322, 256, 203, 162, 128, 102,
                               81, 64, 51, 41, 32, 26, 20, 16};

  // active, volume, pan, global, base sample
  localparam logic [37:0] VEC [10] = '{
    {8'hFF, 4'd0,  8'h00, 2'd0, 16'h03E8},
    {8'h01, 4'd3,  8'h00, 2'd0, 16'hD120},
    {8'hFF, 4'd5,  8'h0F, 2'd0, 16'h4E20},
    {8'hFF, 4'd0,  8'hA3, 2'd1, 16'hB1E0},
    {8'h0F, 4'd2,  8'h21, 2'd2, 16'h7530},
    {8'hFF, 4'd0,  8'h00, 2'd0, 16'h7FFF},
    {8'hFF, 4'd0,  8'h00, 2'd0, 16'h8000},
    {8'h00, 4'd0,  8'h00, 2'd0, 16'h3039},
    {8'hAA, 4'd15, 8'hFF, 2'd3, 16'h8000},
    {8'h55, 4'd1,  8'h52, 2'd0, 16'h1E61}
  };

  function automatic int expect_code(input bit left);
    int sum = 0;
    int code;
    for (int k = 0; k < NCH; k++) begin
      if (act_m[k]) begin
        int v;
        int gp;
        gp = left ? GTAB[(pan_m[k] >> 4) & 15] : GTAB[pan_m[k] & 15];
        v = (smp_m[k] * GTAB[vol_m[k]]) >>> 9;
        v = (v * gp) >>> 9;
        sum += v >>> glob_m;
      end
    end
    code = (sum >>> 2) + 8192;
    if (code < 0) code = 0;
    if (code > 16383) code = 16383;
    return code;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int ch, input int data);
    @(negedge clk);
    wr_en = 1'b1; wr_kind = 2'(kind); wr_chan = CW'(ch); wr_data = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
    case (kind)
      0: vol_m[ch] = data & 15;
      1: pan_m[ch] = data & 255;
      2: glob_m    = data & 3;
      default: ;
    endcase
  endtask

  task automatic load(input logic [15:0] base, input logic [NCH-1:0] act);
    for (int k = 0; k < NCH; k++) begin
      logic signed [15:0] b;
      b = (k % 2 == 1) ? ($signed(base) >>> 1) : $signed(base);
      ch_sample[k*SW +: SW] = b;
      smp_m[k] = int'(b);
    end
    ch_active = act;
    act_m = act;
  endtask

  // strobe, then count edges until the valid pulse is seen
  task automatic run_frame(output int lat);
    @(negedge clk); frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
    lat = 0;
    while (!out_valid && lat < 4 * NCH) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic frame_and_check(input string tag);
    int el, er, lat;
    el = expect_code(1'b1);
    er = expect_code(1'b0);
    run_frame(lat);
    chk({tag, " latency R8"}, lat, NCH);
    chk({tag, " left"}, int'(out_left), el);
    chk({tag, " right"}, int'(out_right), er);
    @(negedge clk);
    chk({tag, " pulse R8"}, int'(out_valid), 0);
  endtask

  initial begin : watchdog
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    int lat, el, er, cnt, hl, hr;
    for (int k = 0; k < NCH; k++) begin vol_m[k] = 0; pan_m[k] = 0; smp_m[k] = 0; end
    glob_m = 0; act_m = '0;

    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 left reset", int'(out_left), 8192);
    chk("R1 right reset", int'(out_right), 8192);
    chk("R1 valid reset", int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);

    // R1 default gains at 0 dB, scale 1
    load(16'h2000, 8'hFF);
    frame_and_check("R1 defaults R5");

    // vector table: R2 R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      for (int k = 0; k < NCH; k++) begin
        wr(0, k, int'(VEC[i][29:26]));
        wr(1, k, int'(VEC[i][25:18]));
      end
      wr(2, 0, int'(VEC[i][17:16]));
      load(VEC[i][15:0], VEC[i][37:30]);
      frame_and_check($sformatf("vec%0d R2 R3 R4 R5 R6 R7", i));
    end

    // R7 explicit saturation codes
    for (int k = 0; k < NCH; k++) begin wr(0, k, 0); wr(1, k, 0); end
    wr(2, 0, 0);
    load(16'h7FFF, 8'hFF);
    run_frame(lat);
    chk("R7 high clamp left", int'(out_left), 16383);
    chk("R7 high clamp right", int'(out_right), 16383);
    load(16'h8000, 8'hFF);
    run_frame(lat);
    chk("R7 low clamp left", int'(out_left), 0);

    // R2 R3 distinct per-channel settings
    for (int k = 0; k < NCH; k++) begin
      wr(0, k, 2 * k);
      wr(1, k, ((k * 3) % 16) * 16 + (15 - 2 * k));
    end
    load(16'h1800, 8'hFF);
    frame_and_check("R2 R3 per-channel");

    // R4 kind 3 writes nothing
    el = expect_code(1'b1);
    for (int k = 0; k < NCH; k++) wr(3, k, 8'hFF);
    run_frame(lat);
    chk("R4 nop write left", int'(out_left), el);

    // R10 sample change after capture edge
    el = expect_code(1'b1);
    er = expect_code(1'b0);
    @(negedge clk); frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
    ch_sample = '1; ch_active = '0;
    lat = 0;
    while (!out_valid && lat < 4 * NCH) begin @(negedge clk); lat++; end
    chk("R10 left captured", int'(out_left), el);
    chk("R10 right captured", int'(out_right), er);

    // R9 strobe during a frame is ignored
    load(16'h4000, 8'hFF);
    el = expect_code(1'b1);
    @(negedge clk); frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
    @(negedge clk);
    load(16'hC000, 8'hFF);
    frame_strobe = 1'b1;
    @(negedge clk); frame_strobe = 1'b0;
    lat = 0;
    while (!out_valid && lat < 4 * NCH) begin @(negedge clk); lat++; end
    chk("R9 first frame left", int'(out_left), el);
    chk("R9 latency kept", lat, NCH - 2);
    hl = int'(out_left); hr = int'(out_right);
    cnt = 0;
    for (int c = 0; c < 2 * NCH; c++) begin
      @(negedge clk);
      if (out_valid) cnt++;
    end
    chk("R9 no second result", cnt, 0);
    chk("R8 hold left", int'(out_left), hl);
    chk("R8 hold right", int'(out_right), hr);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule